// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target has left holding SDA low, usually because a transfer was cut off partway through a byte. A trigger pulse starts the sequence. The sequencer puts the attached bus controller into soft reset and keeps it there. It then leaves both lines released and waits for them to settle. After that it reads the bus back through a synchronizer.

The bus counts as free only when SDA and SCL both read high. While the bus is not free, the sequencer drives SCL low for a fixed number of cycles and then releases it. It waits for the lines to settle and checks the bus again. This repeats until the bus reads free or until the attempt limit is used up. Each extra clock edge lets the target shift out the rest of its byte and release SDA.

At the end the sequencer takes the controller out of reset and asks it to re-initialise. It gives a one-cycle done pulse and a success flag. The success flag stays valid until the next trigger. Callers raise the trigger whenever a new transfer finds the bus not idle, or when an error has left the bus not idle.

Top module: `bus_unstick_seq`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, every output reads 0.
- R2: A trigger seen while the sequencer is idle raises `ctrl_rst_o` on the next clock edge. `ctrl_rst_o` stays high for the whole sequence, including every SCL pulse.
- R3: The bus is free only when both synchronized lines read 1. If it is free at the first check, no SCL pulse is made and `ok_o` is 1. The first check falls SETTLE_CYC cycles after the trigger.
- R4: Each SCL pulse holds `scl_oe_o` at 1 for exactly PULSE_CYC cycles. SCL is then released for SETTLE_CYC cycles, and one check cycle follows before any further action. So `ctrl_rst_o` is high for SETTLE_CYC + 1 + n·(PULSE_CYC + SETTLE_CYC + 1) cycles when n pulses are made.
- R5: The bus is checked before every pulse. Pulsing stops at the first check that finds the bus free. A target that frees SDA on its k-th clock pulse therefore receives exactly k pulses, for any k up to MAX_TRIES.
- R6: At most MAX_TRIES pulses are made per sequence. If the bus is still not free after the last one, the sequence ends with `ok_o` at 0. This includes a bus where SCL itself is held low.
- R7: `done_o` and `reinit_o` are both high for exactly one cycle. That cycle is the first one in which `ctrl_rst_o` is low again.
- R8: `sda_oe_o` is never 1. SDA is only ever released during recovery.
- R9: A trigger that arrives while a sequence is running is ignored and produces no extra `done_o`.
- R10: `ok_o` is cleared when a trigger is accepted. It then holds the outcome from the end of the sequence until the next accepted trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Recovery trigger, sampled when idle |
| sda_in_i | input | 1 | Sensed SDA line level (asynchronous) |
| scl_in_i | input | 1 | Sensed SCL line level (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls SCL low (open-drain enable) |
| sda_oe_o | output | 1 | 1 pulls SDA low; never asserted |
| ctrl_rst_o | output | 1 | Holds the attached bus controller in soft reset |
| reinit_o | output | 1 | One-cycle request to re-initialise the controller |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ok_o | output | 1 | Bus was found free at the end of the last sequence |

## Verification
The checker enforces several properties on every clock cycle:
- Each SCL pulse has exactly the programmed width.
- There is a released gap after every pulse.
- SCL is only pulled while the controller reset is held.
- `done_o` and `reinit_o` coincide with the first cycle of reset release and never stretch beyond one cycle.
- The success flag cannot change mid-sequence.

Other behaviour depends on how the bus answers, so only the bench scenarios can show it. The bench uses a modelled target that frees SDA after a chosen number of clock pulses, and a bus with SCL held low. These scenarios show that the pulse count matches that number, that the limit cuts the loop off with failure, that the sequence length follows from the pulse count, and that a trigger mid-sequence is dropped.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_CHECK,
    ST_LOW,
    ST_RELEASE,
    ST_FINISH
  } unstick_state_e;

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o
);

  for (genvar ln = 0; ln < LINES; ln++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], async_i[ln]};
    end
    assign sync_o[ln] = chain[STAGES-1];
  end

endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             zero_o
);

  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load_i)     cnt <= load_val_i;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);

endmodule

// File: rtl/unstick_tries.sv
module unstick_tries #(
  parameter int MAX_TRIES = 100,
  parameter int CW        = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic incr_i,
  output logic limit_o
);

  logic [CW-1:0] used;

  always_ff @(posedge clk) begin
    if (rst || clear_i) used <= '0;
    else if (incr_i)    used <= used + 1'b1;
  end

  assign limit_o = (used >= CW'(MAX_TRIES));

endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
  import unstick_pkg::*;
#(
  parameter int PULSE_CYC   = 1250,
  parameter int SETTLE_CYC  = 1250,
  parameter int MAX_TRIES   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic sda_in_i,
  input  logic scl_in_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic ctrl_rst_o,
  output logic reinit_o,
  output logic done_o,
  output logic ok_o
);

  localparam int LONGEST = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int TW      = $clog2(LONGEST + 1);

  unstick_state_e st, st_nxt;
  logic [1:0]     lines_sync;
  logic           bus_free;
  logic           tmr_load, tmr_zero;
  logic [TW-1:0]  tmr_val;
  logic           try_clear, try_incr, try_limit;

  unstick_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({scl_in_i, sda_in_i}),
    .sync_o  (lines_sync)
  );

  assign bus_free = &lines_sync;

  unstick_timer #(.WIDTH(TW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  unstick_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk     (clk),
    .rst     (rst),
    .clear_i (try_clear),
    .incr_i  (try_incr),
    .limit_o (try_limit)
  );

  always_comb begin
    st_nxt    = st;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    try_clear = 1'b0;
    try_incr  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start_i) begin
          st_nxt    = ST_HOLD;
          tmr_load  = 1'b1;
          tmr_val   = TW'(SETTLE_CYC - 1);
          try_clear = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) st_nxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (bus_free || try_limit) begin
          st_nxt = ST_FINISH;
        end else begin
          st_nxt   = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = TW'(PULSE_CYC - 1);
          try_incr = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          st_nxt   = ST_RELEASE;
          tmr_load = 1'b1;
          tmr_val  = TW'(SETTLE_CYC - 1);
        end
      end
      ST_RELEASE: begin
        if (tmr_zero) st_nxt = ST_CHECK;
      end
      ST_FINISH: st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      scl_oe_o   <= 1'b0;
      ctrl_rst_o <= 1'b0;
      reinit_o   <= 1'b0;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
    end else begin
      st         <= st_nxt;
      scl_oe_o   <= (st_nxt == ST_LOW);
      ctrl_rst_o <= (st_nxt == ST_HOLD) || (st_nxt == ST_CHECK) ||
                    (st_nxt == ST_LOW)  || (st_nxt == ST_RELEASE);
      reinit_o   <= (st_nxt == ST_FINISH);
      done_o     <= (st_nxt == ST_FINISH);
      if (st == ST_IDLE && start_i)
        ok_o <= 1'b0;
      else if (st == ST_CHECK && st_nxt == ST_FINISH)
        ok_o <= bus_free;
    end
  end

  assign sda_oe_o = 1'b0;

endmodule

// File: rtl/unstick_chk.sv
module unstick_chk #(
  parameter int PULSE_CYC = 1250
) (
  input logic clk,
  input logic rst,
  input logic scl_oe_o,
  input logic ctrl_rst_o,
  input logic reinit_o,
  input logic done_o,
  input logic ok_o
);

  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)           run_len <= '0;
    else if (scl_oe_o) run_len <= run_len + 1;
    else               run_len <= '0;
  end

  a_r4_pulse_max: assert property (@(posedge clk) disable iff (rst)
    scl_oe_o |-> (run_len < 32'(PULSE_CYC)));

  a_r4_pulse_exact: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe_o) |-> ($past(run_len) == 32'(PULSE_CYC - 1)));

  a_r4_release_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe_o) |=> !scl_oe_o);

  a_r2_pulse_in_reset: assert property (@(posedge clk) disable iff (rst)
    scl_oe_o |-> ctrl_rst_o);

  a_r2_reset_before_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe_o) |-> $past(ctrl_rst_o));

  a_r7_done_on_release: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!ctrl_rst_o && reinit_o && $past(ctrl_rst_o)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_reinit_single: assert property (@(posedge clk) disable iff (rst)
    reinit_o |=> !reinit_o);

  a_r10_ok_steady: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rst_o && $past(ctrl_rst_o)) |-> $stable(ok_o));

endmodule

bind bus_unstick_seq unstick_chk #(.PULSE_CYC(PULSE_CYC)) u_unstick_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_oe_o   (scl_oe_o),
  .ctrl_rst_o (ctrl_rst_o),
  .reinit_o   (reinit_o),
  .done_o     (done_o),
  .ok_o       (ok_o)
);

// File: tb/bus_unstick_seq_test.sv
module bus_unstick_seq_test;

  localparam int P = 4;
  localparam int S = 3;
  localparam int M = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  int   sda_hold = 0;
  logic scl_stuck = 1'b0;
  logic sda_in, scl_in;
  logic scl_oe, sda_oe, ctrl_rst, reinit, done, ok;

  int n_checks = 0;
  int n_fail   = 0;
  int done_seen = 0;

  typedef struct { bit ok; int pulses; int rcyc; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  assign sda_in = (sda_hold == 0);
  assign scl_in = !scl_oe && !scl_stuck;

  bus_unstick_seq #(.PULSE_CYC(P), .SETTLE_CYC(S), .MAX_TRIES(M), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .start_i(start), .sda_in_i(sda_in), .scl_in_i(scl_in),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .ctrl_rst_o(ctrl_rst),
    .reinit_o(reinit), .done_o(done), .ok_o(ok)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: counts pulses, reset cycles, widths; pops scoreboard on done
  logic prev_oe = 1'b0;
  int   pulses = 0, rcyc = 0, width = 0;
  bit   width_bad = 0, sda_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (sda_oe) sda_bad = 1;
      if (ctrl_rst) rcyc++;
      if (scl_oe) begin
        width++;
        if (!prev_oe) begin
          pulses++;
          if (sda_hold > 0) sda_hold--;
        end
      end else if (prev_oe) begin
        if (width != P) width_bad = 1;
        width = 0;
      end
      prev_oe = scl_oe;
      if (done) begin
        if (sb_q.size() == 0) begin
          check(0, "R9 extra done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(ok == e.ok, "R3/R6 ok flag", int'(ok), int'(e.ok));
          check(pulses == e.pulses, "R5 pulse count", pulses, e.pulses);
          check(rcyc == e.rcyc, "R4 reset length", rcyc, e.rcyc);
          check(!ctrl_rst && reinit, "R7 done with reset low and reinit",
                int'({ctrl_rst, reinit}), 1);
          check(!width_bad, "R4 pulse width", int'(width_bad), 0);
        end
        pulses = 0; rcyc = 0; width_bad = 0;
        done_seen++;
      end
    end
  end

  task automatic run(input int k, input bit stuck, input bit poke);
    exp_t e;
    int   target;
    e.pulses = stuck ? M : ((k > M) ? M : k);
    e.ok     = !stuck && (k <= M);
    e.rcyc   = S + 1 + e.pulses * (P + S + 1);
    @(negedge clk);
    sda_hold  = k;
    scl_stuck = stuck;
    repeat (4) @(negedge clk);
    sb_q.push_back(e);
    target = done_seen + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(ctrl_rst == 1'b1, "R2 reset raised after trigger", int'(ctrl_rst), 1);
    check(ok == 1'b0, "R10 ok cleared on trigger", int'(ok), 0);
    if (poke) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (done_seen == target);
    repeat (3) @(negedge clk);
    check(ok == e.ok, "R10 ok held after done", int'(ok), int'(e.ok));
    if (poke) begin
      repeat (30) @(negedge clk);
      check(done_seen == target, "R9 trigger while busy ignored", done_seen, target);
      check(ctrl_rst == 1'b0, "R9 no second sequence", int'(ctrl_rst), 0);
    end
    sda_hold  = 0;
    scl_stuck = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({scl_oe, sda_oe, ctrl_rst, reinit, done, ok} == 6'b0, "R1 outputs in reset",
          int'({scl_oe, sda_oe, ctrl_rst, reinit, done, ok}), 0);
    rst = 1'b0;
    @(negedge clk);
    check({scl_oe, sda_oe, ctrl_rst, reinit, done, ok} == 6'b0, "R1 outputs after reset",
          int'({scl_oe, sda_oe, ctrl_rst, reinit, done, ok}), 0);

    run(0, 1'b0, 1'b0);      // R3 bus already free
    run(1, 1'b0, 1'b0);      // R5 one pulse
    run(3, 1'b0, 1'b0);      // R5 several pulses
    run(M, 1'b0, 1'b0);      // R5/R6 freed on the last allowed pulse
    run(M + 1, 1'b0, 1'b0);  // R6 limit exhausted
    run(0, 1'b1, 1'b0);      // R6 SCL held low
    run(2, 1'b0, 1'b1);      // R9 trigger mid-sequence

    check(sb_q.size() == 0, "R7 every sequence ended with done", sb_q.size(), 0);
    check(!sda_bad, "R8 SDA never pulled", int'(sda_bad), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule